// File: doc/BRIEF.md
# Display Status Flags and Frame Interrupt

This block keeps the status byte of a tile-and-sprite display controller and drives its active-low interrupt line. Three sticky flags are collected: a frame flag raised when the raster leaves the last visible line, a sprite-overflow flag raised when a scanline holds one sprite too many, and a sprite-overlap flag raised when two opaque sprite pixels meet. A five-bit field beside them names the sprite that caused the overflow.

The host reads the byte through a read strobe. The byte seen in the strobe cycle is the value before clearing. All three flags drop on the next clock edge unless a new event for that flag arrives in the same cycle. The interrupt line is asserted while the frame flag and the interrupt enable are both high. A status read therefore both acknowledges the frame and releases the line. Video timing and sprite evaluation sit outside; their events arrive as single-cycle strobes. All pins are plain control and status signals, with no handshake.

Top module: `stat_irq_unit`

## Requirements
- R1: After reset the status byte reads 8'h00 and the interrupt line is high (inactive).
- R2: A pulse on `frame_end_i` sets status bit 7 on the next edge, and the bit stays set until a status read.
- R3: A pulse on `ovf_evt_i` sets status bit 6, and a pulse on `coll_evt_i` sets status bit 5, each on the next edge and sticky until a status read.
- R4: A status read returns the current byte and clears bits 7, 6 and 5 on the following edge, leaving bits 4:0 unchanged.
- R5: When a set event and a status read fall in the same cycle, the flag for that event is set after the edge.
- R6: `irq_n_o` is low exactly while status bit 7 and `irq_en_i` are both high, so a read that clears bit 7 releases it.
- R7: While bit 6 is set and no read occurs, bits 4:0 hold their value, whatever `spr_idx_i`, `spr_eval_i` or `ovf_evt_i` do.
- R8: While bit 6 is clear, each `spr_eval_i` strobe loads `spr_idx_i` into bits 4:0 on the next edge.
- R9: An overflow event that finds bit 6 clear, or that coincides with a read, loads its `spr_idx_i` into bits 4:0 together with setting bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_end_i | input | 1 | One-cycle pulse after the last visible line |
| spr_eval_i | input | 1 | Sprite evaluated this cycle, index on `spr_idx_i` |
| ovf_evt_i | input | 1 | Too many sprites on the line, offending index on `spr_idx_i` |
| spr_idx_i | input | 5 | Index of the sprite being evaluated |
| coll_evt_i | input | 1 | Two sprites overlap at a pixel |
| irq_en_i | input | 1 | Interrupt enable from control register 1 |
| stat_rd_i | input | 1 | Host status read strobe |
| stat_o | output | 8 | Status byte: 7 frame, 6 overflow, 5 overlap, 4:0 sprite index |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The hardest situation to reach is an event landing in the exact cycle of a status read. The case is sharpest for the overflow flag, because there the index field must switch from frozen to reloaded at the same edge. Each scenario task drives the read strobe and the event strobe together on one falling edge and samples the byte on the next falling edge. It first sets the flag with a different index, so a lost event or a stale field becomes visible. Repeated overflow and evaluation strobes with new indices are then applied while the flag is set, to show that the field stays frozen.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  localparam int IDX_W     = 5;
  localparam int NFLAG     = 3;
  localparam int BIT_FRAME = 7;
  localparam int BIT_OVF   = 6;
  localparam int BIT_COLL  = 5;
  localparam int FLG_COLL  = 0;
  localparam int FLG_OVF   = 1;
  localparam int FLG_FRAME = 2;
endpackage

// File: rtl/stat_sticky_flag.sv
module stat_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/stat_index_reg.sv
module stat_index_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         held_i,
  input  logic         rd_i,
  input  logic         eval_i,
  input  logic         ovf_i,
  input  logic [W-1:0] idx_i,
  output logic [W-1:0] idx_o
);
  logic open_w;
  assign open_w = !held_i || rd_i;

  always_ff @(posedge clk) begin
    if (!rst_n)                          idx_o <= '0;
    else if (open_w && (eval_i || ovf_i)) idx_o <= idx_i;
  end
endmodule

// File: rtl/stat_irq_drive.sv
module stat_irq_drive (
  input  logic frame_i,
  input  logic en_i,
  output logic irq_n_o
);
  assign irq_n_o = !(frame_i && en_i);
endmodule

// File: rtl/stat_irq_unit.sv
module stat_irq_unit
  import stat_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end_i,
  input  logic             spr_eval_i,
  input  logic             ovf_evt_i,
  input  logic [IDX_W-1:0] spr_idx_i,
  input  logic             coll_evt_i,
  input  logic             irq_en_i,
  input  logic             stat_rd_i,
  output logic [7:0]       stat_o,
  output logic             irq_n_o
);
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] flag_q;
  logic [IDX_W-1:0] idx_q;

  assign set_v[FLG_COLL]  = coll_evt_i;
  assign set_v[FLG_OVF]   = ovf_evt_i;
  assign set_v[FLG_FRAME] = frame_end_i;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    stat_sticky_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v[g]),
      .clr_i (stat_rd_i),
      .q_o   (flag_q[g])
    );
  end

  stat_index_reg #(.W(IDX_W)) u_idx (
    .clk    (clk),
    .rst_n  (rst_n),
    .held_i (flag_q[FLG_OVF]),
    .rd_i   (stat_rd_i),
    .eval_i (spr_eval_i),
    .ovf_i  (ovf_evt_i),
    .idx_i  (spr_idx_i),
    .idx_o  (idx_q)
  );

  stat_irq_drive u_irq (
    .frame_i (flag_q[FLG_FRAME]),
    .en_i    (irq_en_i),
    .irq_n_o (irq_n_o)
  );

  always_comb begin
    stat_o            = '0;
    stat_o[BIT_FRAME] = flag_q[FLG_FRAME];
    stat_o[BIT_OVF]   = flag_q[FLG_OVF];
    stat_o[BIT_COLL]  = flag_q[FLG_COLL];
    stat_o[IDX_W-1:0] = idx_q;
  end
endmodule

// File: rtl/stat_irq_unit_chk.sv
module stat_irq_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_end_i,
  input logic       spr_eval_i,
  input logic       ovf_evt_i,
  input logic [4:0] spr_idx_i,
  input logic       coll_evt_i,
  input logic       irq_en_i,
  input logic       stat_rd_i,
  input logic [7:0] stat_o,
  input logic       irq_n_o
);
  AST_FRAME_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[7] && !stat_rd_i |=> stat_o[7]); // R2
  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt_i |=> stat_o[6]); // R3
  AST_COLL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt_i |=> stat_o[5]); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_i && !frame_end_i |=> !stat_o[7]); // R4
  AST_SET_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_i && frame_end_i |=> stat_o[7]); // R5
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> stat_o[7] && irq_en_i); // R6
  AST_IDX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[6] && !stat_rd_i |=> $stable(stat_o[4:0])); // R7
  AST_OVF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt_i && (!stat_o[6] || stat_rd_i) |=> stat_o[4:0] == $past(spr_idx_i)); // R9
endmodule

bind stat_irq_unit stat_irq_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_end_i(frame_end_i), .spr_eval_i(spr_eval_i),
  .ovf_evt_i(ovf_evt_i), .spr_idx_i(spr_idx_i), .coll_evt_i(coll_evt_i),
  .irq_en_i(irq_en_i), .stat_rd_i(stat_rd_i), .stat_o(stat_o), .irq_n_o(irq_n_o)
);

// File: tb/sim_stat_irq_unit.sv
`timescale 1ns/1ps
module sim_stat_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_end_i = 1'b0, spr_eval_i = 1'b0, ovf_evt_i = 1'b0;
  logic [4:0] spr_idx_i = '0;
  logic       coll_evt_i = 1'b0, irq_en_i = 1'b0, stat_rd_i = 1'b0;
  logic [7:0] stat_o;
  logic       irq_n_o;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  stat_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .frame_end_i(frame_end_i), .spr_eval_i(spr_eval_i),
    .ovf_evt_i(ovf_evt_i), .spr_idx_i(spr_idx_i), .coll_evt_i(coll_evt_i),
    .irq_en_i(irq_en_i), .stat_rd_i(stat_rd_i), .stat_o(stat_o), .irq_n_o(irq_n_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // drive strobes for one cycle starting at a falling edge, return at next falling edge
  task automatic strobe(input bit fe, input bit ev, input bit ov, input bit co,
                        input bit rd, input logic [4:0] idx);
    frame_end_i = fe; spr_eval_i = ev; ovf_evt_i = ov; coll_evt_i = co;
    stat_rd_i = rd; spr_idx_i = idx;
    @(negedge clk);
    frame_end_i = 0; spr_eval_i = 0; ovf_evt_i = 0; coll_evt_i = 0; stat_rd_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 status", stat_o, 8'h00);
    chk("R1 irq", {7'd0, irq_n_o}, 8'h01);
  endtask

  task automatic t_frame();
    irq_en_i = 0;
    strobe(1, 0, 0, 0, 0, 5'd0);
    chk("R2 frame set", stat_o, 8'h80);
    chk("R6 irq disabled", {7'd0, irq_n_o}, 8'h01);
    repeat (3) @(negedge clk);
    chk("R2 frame sticky", stat_o, 8'h80);
    irq_en_i = 1; #1;
    chk("R6 irq low", {7'd0, irq_n_o}, 8'h00);
    strobe(0, 0, 0, 0, 1, 5'd0);
    chk("R4 frame cleared", stat_o, 8'h00);
    chk("R6 irq released", {7'd0, irq_n_o}, 8'h01);
    irq_en_i = 0;
  endtask

  task automatic t_sprite();
    strobe(0, 1, 0, 0, 0, 5'd3);
    chk("R8 track 3", stat_o, 8'h03);
    strobe(0, 1, 0, 0, 0, 5'd7);
    chk("R8 track 7", stat_o, 8'h07);
    strobe(0, 1, 1, 0, 0, 5'd9);
    chk("R3/R9 overflow 9", stat_o, 8'h49);
    strobe(0, 1, 0, 0, 0, 5'd12);
    chk("R7 frozen vs eval", stat_o, 8'h49);
    strobe(0, 1, 1, 0, 0, 5'd20);
    chk("R7 frozen vs ovf", stat_o, 8'h49);
    strobe(0, 0, 0, 1, 0, 5'd0);
    chk("R3 overlap set", stat_o, 8'h69);
    strobe(0, 0, 0, 0, 1, 5'd0);
    chk("R4 flags cleared idx kept", stat_o, 8'h09);
    strobe(0, 1, 0, 0, 0, 5'd12);
    chk("R8 track after read", stat_o, 8'h0C);
  endtask

  task automatic t_race();
    strobe(1, 0, 0, 0, 0, 5'd0);
    strobe(1, 0, 0, 0, 1, 5'd0);
    chk("R5 frame set beats read", stat_o, 8'h8C);
    strobe(0, 1, 1, 0, 1, 5'd4);
    chk("R5/R9 ovf with read", stat_o, 8'h44);
    strobe(0, 1, 1, 1, 1, 5'd17);
    chk("R5/R9 ovf reload on read", stat_o, 8'h71);
    strobe(0, 0, 0, 0, 1, 5'd0);
    chk("R4 all clear", stat_o, 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_frame();
    t_sprite();
    t_race();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule